// File: doc/BRIEF.md
# Trap Return Privilege Unit

This unit executes the two return-from-trap operations of a processor core: the machine-level return and the supervisor-level return. A single-cycle request names the kind of return. The unit samples the current privilege mode, the status-register fields that hold the interrupt-enable stack, both saved exception PCs and a strap that says whether compressed instructions are supported. It first checks that the return is legal. The return must be permitted at the current privilege, and the saved PC it jumps to must be aligned. When the return is legal, the unit pops the enable stack and switches the privilege mode. When it is not legal, the unit reports which exception applies and leaves all state untouched.

Results are registered. They appear on the clock edge that samples the request, together with a one-cycle `done` pulse. Between requests the outputs keep their last values, so the core can hold them in its architectural state.

Top module: `trap_return_unit`

## Requirements
- R1: Privilege encodings are 0 = user, 1 = supervisor, 3 = machine. `ret_machine` = 1 selects the machine return and 0 selects the supervisor return. A machine return requested while `cur_priv` is not 3 raises `exc_illegal`.
- R2: A supervisor return requested at user privilege (`cur_priv` = 0) raises `exc_illegal`. At supervisor or machine privilege it is allowed.
- R3: With `c_present` = 0, a permitted return whose selected saved PC has a nonzero bits [1:0] raises `exc_misaligned`. With `c_present` = 1, the same PC raises no exception. A privilege violation takes precedence, so the two flags are never high together.
- R4: A legal machine return copies the old machine previous-enable into the machine enable, clears the machine previous-enable, and sets the machine previous-privilege to 0. The supervisor fields stay unchanged.
- R5: A legal supervisor return copies the old supervisor previous-enable into the supervisor enable, clears the supervisor previous-enable, and sets the supervisor previous-privilege to 0. The machine fields stay unchanged.
- R6: After a legal return, `priv_out` is the old previous-privilege of the level being left. For the supervisor return this is 0 or 1. For the machine return it is 0, 1 or 3, and the reserved value 2 yields user (0).
- R7: `pc_next` is `mepc` for a machine return and `sepc` for a supervisor return. This holds whether or not an exception is raised.
- R8: When either exception is raised, `status_out` equals the sampled `status_in` and `priv_out` equals the sampled `cur_priv`.
- R9: Results and `done` change on the clock edge that samples `req_valid` = 1. `done` is high for exactly that one cycle when no request follows. All other outputs hold their values while no request is presented.
- R10: `status_in` and `status_out` pack the fields as [0] supervisor enable, [1] machine enable, [2] supervisor previous-enable, [3] machine previous-enable, [4] supervisor previous-privilege, [6:5] machine previous-privilege. After reset, `done`, both flags, `pc_next` and `status_out` are 0 and `priv_out` is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Return request, one cycle |
| ret_machine | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege mode |
| status_in | input | 7 | Current enable-stack fields (layout in R10) |
| mepc | input | XLEN | Machine saved exception PC |
| sepc | input | XLEN | Supervisor saved exception PC |
| c_present | input | 1 | Compressed instructions supported |
| done | output | 1 | Result-valid pulse |
| pc_next | output | XLEN | Return target |
| status_out | output | 7 | Updated enable-stack fields |
| priv_out | output | 2 | New privilege mode |
| exc_illegal | output | 1 | Illegal-instruction exception |
| exc_misaligned | output | 1 | Instruction-address-misaligned exception |

## Verification
A wrong enable-stack update shows up in `status_out` one cycle after the request, on the same edge that raises `done`. Swapped machine and supervisor fields therefore appear in the first return that has asymmetric field values. A wrong privilege decision or a wrong alignment decision shows up in the same cycle, either as a wrong exception flag or as state that changes when it should have stayed unchanged. The directed returns use distinct values for every field and both saved PCs, so any mixing of sources is visible at the ports on that first result.

// File: rtl/trap_return_pkg.sv
package trap_return_pkg;

   typedef enum logic [1:0] {
      PRIV_USER  = 2'd0,
      PRIV_SUPER = 2'd1,
      PRIV_RSVD  = 2'd2,
      PRIV_MACH  = 2'd3
   } priv_e;

   typedef struct packed {
      logic [1:0] m_prev_priv;
      logic       s_prev_priv;
      logic       m_prev_ie;
      logic       s_prev_ie;
      logic       m_ie;
      logic       s_ie;
   } ie_stack_t;

   localparam int STACK_W = $bits(ie_stack_t);

   // compressed-support selection
   localparam int CMODE_NEVER   = 0;
   localparam int CMODE_ALWAYS  = 1;
   localparam int CMODE_RUNTIME = 2;

endpackage

// File: rtl/trap_return_check.sv
module trap_return_check
   import trap_return_pkg::*;
#(
   parameter int C_MODE = CMODE_RUNTIME
) (
   input  logic       is_machine,
   input  logic [1:0] priv_now,
   input  logic [1:0] target_low,
   input  logic       c_strap,
   output logic       illegal,
   output logic       misaligned
);
   logic c_eff;
   logic priv_ok;

   generate
      if (C_MODE == CMODE_NEVER) begin : g_c_never
         assign c_eff = 1'b0;
      end else if (C_MODE == CMODE_ALWAYS) begin : g_c_always
         assign c_eff = 1'b1;
      end else if (C_MODE == CMODE_RUNTIME) begin : g_c_runtime
         assign c_eff = c_strap;
      end else begin : g_c_bad
         $error("trap_return_check: C_MODE out of range");
         assign c_eff = 1'b0;
      end
   endgenerate

   always_comb begin
      if (is_machine) priv_ok = (priv_now == PRIV_MACH);
      else            priv_ok = (priv_now != PRIV_USER);
   end

   assign illegal    = !priv_ok;
   assign misaligned = priv_ok && !c_eff && (target_low != 2'b00);

   always_comb begin
      a_r3_flags_exclusive: assert (!(illegal && misaligned))
         else $error("both exception flags set");
   end
endmodule

// File: rtl/trap_return_update.sv
module trap_return_update
   import trap_return_pkg::*;
(
   input  logic       is_machine,
   input  ie_stack_t  st_old,
   output ie_stack_t  st_new,
   output logic [1:0] priv_new
);
   always_comb begin
      st_new   = st_old;
      priv_new = PRIV_USER;
      if (is_machine) begin
         st_new.m_ie        = st_old.m_prev_ie;
         st_new.m_prev_ie   = 1'b0;
         st_new.m_prev_priv = PRIV_USER;
         priv_new = (st_old.m_prev_priv == PRIV_RSVD) ? PRIV_USER : st_old.m_prev_priv;
      end else begin
         st_new.s_ie        = st_old.s_prev_ie;
         st_new.s_prev_ie   = 1'b0;
         st_new.s_prev_priv = 1'b0;
         priv_new = {1'b0, st_old.s_prev_priv};
      end
   end

   always_comb begin
      a_r6_no_reserved_priv: assert (priv_new != PRIV_RSVD)
         else $error("reserved privilege produced");
   end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
   import trap_return_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          C_MODE     = CMODE_RUNTIME,
   parameter logic [1:0]  RESET_PRIV = 2'd3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic            ret_machine,
   input  logic [1:0]      cur_priv,
   input  logic [6:0]      status_in,
   input  logic [XLEN-1:0] mepc,
   input  logic [XLEN-1:0] sepc,
   input  logic            c_present,
   output logic            done,
   output logic [XLEN-1:0] pc_next,
   output logic [6:0]      status_out,
   output logic [1:0]      priv_out,
   output logic            exc_illegal,
   output logic            exc_misaligned
);
   localparam int PC_LSB_W = 2;

   generate
      if (XLEN < 8) begin : g_xlen_bad
         $error("trap_return_unit: XLEN too small");
      end
      if (STACK_W != 7) begin : g_stack_bad
         $error("trap_return_unit: status layout width mismatch");
      end
   endgenerate

   logic [XLEN-1:0] target_pc;
   logic            bad_priv, bad_align;
   ie_stack_t       st_cur, st_upd;
   logic [1:0]      priv_upd;

   assign target_pc = ret_machine ? mepc : sepc;
   assign st_cur    = ie_stack_t'(status_in);

   trap_return_check #(.C_MODE(C_MODE)) u_check (
      .is_machine (ret_machine),
      .priv_now   (cur_priv),
      .target_low (target_pc[PC_LSB_W-1:0]),
      .c_strap    (c_present),
      .illegal    (bad_priv),
      .misaligned (bad_align)
   );

   trap_return_update u_update (
      .is_machine (ret_machine),
      .st_old     (st_cur),
      .st_new     (st_upd),
      .priv_new   (priv_upd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done           <= 1'b0;
         pc_next        <= '0;
         status_out     <= '0;
         priv_out       <= RESET_PRIV;
         exc_illegal    <= 1'b0;
         exc_misaligned <= 1'b0;
      end else begin
         done <= req_valid;
         if (req_valid) begin
            pc_next        <= target_pc;
            exc_illegal    <= bad_priv;
            exc_misaligned <= bad_align;
            if (bad_priv || bad_align) begin
               status_out <= status_in;
               priv_out   <= cur_priv;
            end else begin
               status_out <= st_upd;
               priv_out   <= priv_upd;
            end
         end
      end
   end

   a_r1_mret_needs_machine: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ret_machine && cur_priv != 2'd3) |=> exc_illegal);

   a_r2_sret_from_user: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !ret_machine && cur_priv == 2'd0) |=> exc_illegal);

   a_r8_exc_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (bad_priv || bad_align)) |=>
         (status_out == $past(status_in) && priv_out == $past(cur_priv)));

   a_r4_mret_pops_stack: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ret_machine && !bad_priv && !bad_align) |=>
         (status_out[6:5] == 2'd0 && !status_out[3] && status_out[1] == $past(status_in[3])));

   a_r9_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> done);

   a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!done && $stable(pc_next) && $stable(status_out) && $stable(priv_out)));
endmodule

// File: tb/trap_return_unit_test.sv
module trap_return_unit_test;
   localparam int  XLEN   = 32;
   localparam time CLK_HP = 5ns;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            ret_machine = 1'b0;
   logic [1:0]      cur_priv = 2'd0;
   logic [6:0]      status_in = '0;
   logic [XLEN-1:0] mepc = '0;
   logic [XLEN-1:0] sepc = '0;
   logic            c_present = 1'b0;
   logic            done;
   logic [XLEN-1:0] pc_next;
   logic [6:0]      status_out;
   logic [1:0]      priv_out;
   logic            exc_illegal, exc_misaligned;

   int n_checks = 0;
   int n_errors = 0;

   trap_return_unit #(.XLEN(XLEN)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ret_machine(ret_machine),
      .cur_priv(cur_priv), .status_in(status_in), .mepc(mepc), .sepc(sepc),
      .c_present(c_present), .done(done), .pc_next(pc_next), .status_out(status_out),
      .priv_out(priv_out), .exc_illegal(exc_illegal), .exc_misaligned(exc_misaligned)
   );

   always #(CLK_HP) clk = ~clk;

   task automatic check(input string tag, input logic [XLEN-1:0] e_pc,
                        input logic [6:0] e_st, input logic [1:0] e_pr,
                        input logic e_ill, input logic e_mis, input logic e_done);
      n_checks++;
      if (pc_next !== e_pc || status_out !== e_st || priv_out !== e_pr ||
          exc_illegal !== e_ill || exc_misaligned !== e_mis || done !== e_done) begin
         n_errors++;
         $display("FAIL %s: got pc=%h st=%b pr=%0d ill=%b mis=%b done=%b exp pc=%h st=%b pr=%0d ill=%b mis=%b done=%b",
                  tag, pc_next, status_out, priv_out, exc_illegal, exc_misaligned, done,
                  e_pc, e_st, e_pr, e_ill, e_mis, e_done);
      end
   endtask

   // drive one request at a falling edge; return at the next falling edge
   task automatic issue(input logic mach, input logic [1:0] pr, input logic [6:0] st,
                        input logic [XLEN-1:0] m_pc, input logic [XLEN-1:0] s_pc,
                        input logic c);
      @(negedge clk);
      ret_machine = mach; cur_priv = pr; status_in = st;
      mepc = m_pc; sepc = s_pc; c_present = c; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_reset();
      check("R10 reset", '0, 7'b0, 2'd3, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_mret_to_super();
      // mpp=1 spp=1 mpie=1 spie=1 mie=0 sie=0
      issue(1'b1, 2'd3, 7'b0111100, 32'h8000_1000, 32'h4000_2000, 1'b0);
      check("R4 R6 R7 mret to super", 32'h8000_1000, 7'b0010110, 2'd1, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_mret_to_machine();
      // mpp=3 spp=0 mpie=0 spie=1 mie=1 sie=1
      issue(1'b1, 2'd3, 7'b1100111, 32'h0000_0104, 32'h0000_0208, 1'b0);
      check("R4 R6 mret stays machine", 32'h0000_0104, 7'b0000101, 2'd3, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_mret_reserved();
      // mpp=2 mpie=1 others 0
      issue(1'b1, 2'd3, 7'b1001000, 32'h0000_0040, 32'h0, 1'b0);
      check("R6 reserved prev priv gives user", 32'h0000_0040, 7'b0000010, 2'd0, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_mret_illegal();
      issue(1'b1, 2'd1, 7'b0111100, 32'h0000_0800, 32'h0000_0900, 1'b0);
      check("R1 R8 mret from super illegal", 32'h0000_0800, 7'b0111100, 2'd1, 1'b1, 1'b0, 1'b1);
   endtask

   task automatic t_sret_from_super();
      // mpp=3 spp=0 mpie=1 spie=1 mie=1 sie=0
      issue(1'b0, 2'd1, 7'b1101110, 32'h1111_0000, 32'h2222_0010, 1'b0);
      check("R5 R6 R7 sret to user", 32'h2222_0010, 7'b1101011, 2'd0, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_sret_from_machine();
      // mpp=0 spp=1 mpie=0 spie=0 mie=1 sie=1
      issue(1'b0, 2'd3, 7'b0010011, 32'h0, 32'h0000_0abc, 1'b0);
      check("R2 R5 R6 sret from machine", 32'h0000_0abc, 7'b0000010, 2'd1, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_sret_illegal();
      issue(1'b0, 2'd0, 7'b0010100, 32'h0, 32'h0000_0c00, 1'b0);
      check("R2 R8 sret from user illegal", 32'h0000_0c00, 7'b0010100, 2'd0, 1'b1, 1'b0, 1'b1);
   endtask

   task automatic t_misaligned();
      issue(1'b1, 2'd3, 7'b0111100, 32'h0000_1002, 32'h0, 1'b0);
      check("R3 R8 mret misaligned", 32'h0000_1002, 7'b0111100, 2'd3, 1'b0, 1'b1, 1'b1);
      issue(1'b0, 2'd1, 7'b1101110, 32'h0, 32'h0000_2001, 1'b0);
      check("R3 R8 sret misaligned", 32'h0000_2001, 7'b1101110, 2'd1, 1'b0, 1'b1, 1'b1);
   endtask

   task automatic t_compressed_ok();
      issue(1'b1, 2'd3, 7'b0111100, 32'h0000_1002, 32'h0, 1'b1);
      check("R3 compressed allows half alignment", 32'h0000_1002, 7'b0010110, 2'd1, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_precedence();
      issue(1'b1, 2'd0, 7'b0001000, 32'h0000_0003, 32'h0, 1'b0);
      check("R3 R1 illegal wins over misaligned", 32'h0000_0003, 7'b0001000, 2'd0, 1'b1, 1'b0, 1'b1);
   endtask

   task automatic t_idle_hold();
      issue(1'b0, 2'd1, 7'b1101110, 32'h0, 32'h0000_0500, 1'b0);
      check("R9 result on sampling edge", 32'h0000_0500, 7'b1101011, 2'd0, 1'b0, 1'b0, 1'b1);
      status_in = 7'b1111111; cur_priv = 2'd3; sepc = 32'hffff_ffff; ret_machine = 1'b1;
      @(negedge clk);
      check("R9 done drops and outputs hold", 32'h0000_0500, 7'b1101011, 2'd0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      check("R9 still holding", 32'h0000_0500, 7'b1101011, 2'd0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin : main
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 idle after reset", '0, 7'b0, 2'd3, 1'b0, 1'b0, 1'b0);
      t_mret_to_super();
      t_mret_to_machine();
      t_mret_reserved();
      t_mret_illegal();
      t_sret_from_super();
      t_sret_from_machine();
      t_sret_illegal();
      t_misaligned();
      t_compressed_ok();
      t_precedence();
      t_idle_hold();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule